// File: doc/BRIEF.md
# Two-Phase Fan Commutation Sequencer

This block commutates a two-phase brushless fan motor from one hall-sensor line. It chooses which of the two coil-pair drives (L1 or L2) is energized, gates the chosen drive with an externally generated PWM carrier, and reports a stalled rotor on an active-low lock flag meant for the fan's sense wire. A one-clock commutation strobe is issued on every accepted hall edge while the motor runs, so a separate speed loop can measure the time per quarter turn (four edges per revolution).

After reset or restart the sequencer aligns the rotor by energizing L1, samples the filtered hall level at two tick counts, then energizes L2 and waits for the hall line to read low before switching back to L1 and entering normal running. In running, each hall edge swaps the energized pair. If no edge arrives within a tick window, or a startup step waits too long, both drives are forced off and the lock flag goes low; after a long hold-off the whole sequence starts again from alignment. All time windows are counted in pulses of the `tick` input, so the timebase is set outside the block.

Top module: `fan_commutator`

## Requirements
- R1: At most one of `coilL1`/`coilL2` is high at any time; the selected pair's output equals `pwmGate`, and both are low while locked.
- R2: While running, every accepted hall edge, rising or falling, swaps the selected pair.
- R3: From reset or restart L1 is selected (alignment). If the filtered hall level is high on tick number START_SAMPLE1_TICKS after alignment began, L2 is selected (seek); otherwise L2 is selected on tick number START_SAMPLE2_TICKS whatever the level. In seek, as soon as the filtered hall level is low, L1 is selected and running begins.
- R4: If the filtered hall level is still high on tick number SEEK_TIMEOUT_TICKS after seek began, the block locks.
- R5: While running, if tick number LOCK_TICKS arrives with no accepted hall edge since the last edge (or since running began), the block locks; an accepted edge restarts the count.
- R6: While locked, `lockN` is low and both coil outputs are low.
- R7: On tick number HOLDOFF_TICKS after the lock began, `lockN` returns high and the block restarts at alignment with L1 selected and its tick count cleared.
- R8: `commStrobe` is high for exactly one clock for each accepted hall edge while running, and never outside running.
- R9: A hall change is accepted only after the synchronised level has differed from the accepted level for FILT_LEN consecutive clocks; shorter pulses cause no swap and no strobe.
- R10: Asynchronous active-low reset puts the block in alignment: `coilL1` follows `pwmGate`, `coilL2` low, `lockN` high, `commStrobe` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hallIn | input | 1 | Raw hall-sensor level, asynchronous |
| pwmGate | input | 1 | PWM carrier gating the selected coil pair |
| tick | input | 1 | One-clock timebase pulse |
| coilL1 | output | 1 | Drive enable, coil pair L1 |
| coilL2 | output | 1 | Drive enable, coil pair L2 |
| lockN | output | 1 | Low while the rotor is declared locked |
| commStrobe | output | 1 | One-clock pulse per accepted edge in running |

## Verification
A wrong sequencer state shows at the ports within one clock: the selected pair, the lock flag and the strobe are all direct functions of it, so a behavioural model compared every cycle catches a missed swap, a spurious strobe or an early lock on the cycle it occurs. Faults in the tick window counter only surface at the next window boundary, one tick period later, as a lock or restart at the wrong time; the bench therefore also measures the stall-to-lock and lock-to-restart intervals. Filter faults appear as a swap after a short glitch, or as an acceptance delay off by a clock.

// File: rtl/fan_seq_pkg.sv
package fan_seq_pkg;

  typedef enum logic [1:0] {
    ST_ALIGN = 2'd0,
    ST_SEEK  = 2'd1,
    ST_RUN   = 2'd2,
    ST_LOCK  = 2'd3
  } seqState_t;

  // Strobes from the sequencer control to the hall datapath.
  typedef struct packed {
    logic winClr;
  } ctlStrobe_t;

endpackage

// File: rtl/fan_hall_dp.sv
module fan_hall_dp
  import fan_seq_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 4,
  parameter int WIN_W       = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             hallIn,
  input  logic             tick,
  input  ctlStrobe_t       ctl,
  output logic             hallLvl,
  output logic             hallEdge,
  output logic [WIN_W-1:0] winCnt
);

  localparam int FCW = $clog2(FILT_LEN + 1);
  localparam logic [FCW-1:0] FILT_LAST = FCW'(FILT_LEN - 1);

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   hallSync;
  logic [FCW-1:0]         filtCnt;

  // Synchroniser chain; the newest sample enters at bit 0.
  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) syncQ <= '0;
        else       syncQ <= hallIn;
    end else begin : g_syncN
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) syncQ <= '0;
        else       syncQ <= {syncQ[SYNC_STAGES-2:0], hallIn};
    end
  endgenerate

  assign hallSync = syncQ[SYNC_STAGES-1];

  // Glitch filter: accept a new level after FILT_LEN agreeing clocks.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hallLvl  <= 1'b0;
      filtCnt  <= '0;
      hallEdge <= 1'b0;
    end else if (hallSync != hallLvl) begin
      if (filtCnt == FILT_LAST) begin
        hallLvl  <= hallSync;
        filtCnt  <= '0;
        hallEdge <= 1'b1;
      end else begin
        filtCnt  <= filtCnt + 1'b1;
        hallEdge <= 1'b0;
      end
    end else begin
      filtCnt  <= '0;
      hallEdge <= 1'b0;
    end
  end

  // Tick window counter shared by all sequencer states.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                       winCnt <= '0;
    else if (ctl.winClr)             winCnt <= '0;
    else if (tick && winCnt != '1)   winCnt <= winCnt + 1'b1;
  end

  p_edge_marks_change_r9: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(hallLvl) |-> hallEdge);

  p_edge_after_stable_r9: assert property (@(posedge clk) disable iff (!rstN)
    hallEdge |-> $past(hallSync) == hallLvl);

  p_win_cleared_r5: assert property (@(posedge clk) disable iff (!rstN)
    ctl.winClr |=> winCnt == '0);

endmodule

// File: rtl/fan_seq_ctl.sv
module fan_seq_ctl
  import fan_seq_pkg::*;
#(
  parameter int WIN_W               = 7,
  parameter int START_SAMPLE1_TICKS = 2,
  parameter int START_SAMPLE2_TICKS = 3,
  parameter int SEEK_TIMEOUT_TICKS  = 4,
  parameter int LOCK_TICKS          = 4,
  parameter int HOLDOFF_TICKS       = 100
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             hallLvl,
  input  logic             hallEdge,
  input  logic [WIN_W-1:0] winCnt,
  input  logic             tick,
  input  logic             pwmGate,
  output ctlStrobe_t       ctl,
  output logic             coilL1,
  output logic             coilL2,
  output logic             lockN,
  output logic             commStrobe
);

  localparam logic [WIN_W-1:0] SAMP1_LAST = WIN_W'(START_SAMPLE1_TICKS - 1);
  localparam logic [WIN_W-1:0] SAMP2_LAST = WIN_W'(START_SAMPLE2_TICKS - 1);
  localparam logic [WIN_W-1:0] SEEK_LAST  = WIN_W'(SEEK_TIMEOUT_TICKS - 1);
  localparam logic [WIN_W-1:0] LOCK_LAST  = WIN_W'(LOCK_TICKS - 1);
  localparam logic [WIN_W-1:0] HOLD_LAST  = WIN_W'(HOLDOFF_TICKS - 1);

  seqState_t state, nState;
  logic      phase, nPhase;   // 0 selects L1, 1 selects L2
  logic      nStrobe;
  logic      winClr;

  always_comb begin
    nState  = state;
    nPhase  = phase;
    nStrobe = 1'b0;
    winClr  = 1'b0;
    unique case (state)
      ST_ALIGN: begin
        if (tick && ((winCnt == SAMP1_LAST && hallLvl) || winCnt == SAMP2_LAST)) begin
          nState = ST_SEEK;
          nPhase = 1'b1;
          winClr = 1'b1;
        end
      end
      ST_SEEK: begin
        if (!hallLvl) begin
          nState = ST_RUN;
          nPhase = 1'b0;
          winClr = 1'b1;
        end else if (tick && winCnt == SEEK_LAST) begin
          nState = ST_LOCK;
          winClr = 1'b1;
        end
      end
      ST_RUN: begin
        if (hallEdge) begin
          nPhase  = ~phase;
          nStrobe = 1'b1;
          winClr  = 1'b1;
        end else if (tick && winCnt == LOCK_LAST) begin
          nState = ST_LOCK;
          winClr = 1'b1;
        end
      end
      ST_LOCK: begin
        if (tick && winCnt == HOLD_LAST) begin
          nState = ST_ALIGN;
          nPhase = 1'b0;
          winClr = 1'b1;
        end
      end
      default: begin
        nState = ST_LOCK;
        winClr = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_ALIGN;
      phase      <= 1'b0;
      commStrobe <= 1'b0;
    end else begin
      state      <= nState;
      phase      <= nPhase;
      commStrobe <= nStrobe;
    end
  end

  assign ctl    = '{winClr: winClr};
  assign lockN  = (state != ST_LOCK);
  assign coilL1 = lockN && !phase && pwmGate;
  assign coilL2 = lockN &&  phase && pwmGate;

  p_swap_on_edge_r2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && hallEdge) |=> (phase != $past(phase)) && state == ST_RUN);

  p_seek_timeout_r4: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SEEK && hallLvl && tick && winCnt == SEEK_LAST) |=> !lockN);

  p_run_stall_r5: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && !hallEdge && tick && winCnt == LOCK_LAST) |=> !lockN);

  p_restart_r7: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_LOCK && tick && winCnt == HOLD_LAST) |=> lockN && !phase && state == ST_ALIGN);

  p_strobe_single_r8: assert property (@(posedge clk) disable iff (!rstN)
    commStrobe |=> !commStrobe);

  p_strobe_in_run_r8: assert property (@(posedge clk) disable iff (!rstN)
    commStrobe |-> $past(state) == ST_RUN);

endmodule

// File: rtl/fan_commutator.sv
module fan_commutator #(
  parameter int SYNC_STAGES         = 2,
  parameter int FILT_LEN            = 4,
  parameter int START_SAMPLE1_TICKS = 2,
  parameter int START_SAMPLE2_TICKS = 3,
  parameter int SEEK_TIMEOUT_TICKS  = 4,
  parameter int LOCK_TICKS          = 4,
  parameter int HOLDOFF_TICKS       = 100
) (
  input  logic clk,
  input  logic rstN,
  input  logic hallIn,
  input  logic pwmGate,
  input  logic tick,
  output logic coilL1,
  output logic coilL2,
  output logic lockN,
  output logic commStrobe
);

  import fan_seq_pkg::*;

  localparam int MAX_A = (START_SAMPLE2_TICKS > SEEK_TIMEOUT_TICKS) ? START_SAMPLE2_TICKS : SEEK_TIMEOUT_TICKS;
  localparam int MAX_B = (LOCK_TICKS > HOLDOFF_TICKS) ? LOCK_TICKS : HOLDOFF_TICKS;
  localparam int MAX_T = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int WIN_W = $clog2(MAX_T + 1);

  ctlStrobe_t       ctl;
  logic             hallLvl;
  logic             hallEdge;
  logic [WIN_W-1:0] winCnt;

  fan_hall_dp #(
    .SYNC_STAGES(SYNC_STAGES),
    .FILT_LEN   (FILT_LEN),
    .WIN_W      (WIN_W)
  ) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .hallIn  (hallIn),
    .tick    (tick),
    .ctl     (ctl),
    .hallLvl (hallLvl),
    .hallEdge(hallEdge),
    .winCnt  (winCnt)
  );

  fan_seq_ctl #(
    .WIN_W              (WIN_W),
    .START_SAMPLE1_TICKS(START_SAMPLE1_TICKS),
    .START_SAMPLE2_TICKS(START_SAMPLE2_TICKS),
    .SEEK_TIMEOUT_TICKS (SEEK_TIMEOUT_TICKS),
    .LOCK_TICKS         (LOCK_TICKS),
    .HOLDOFF_TICKS      (HOLDOFF_TICKS)
  ) ctl_i (
    .clk       (clk),
    .rstN      (rstN),
    .hallLvl   (hallLvl),
    .hallEdge  (hallEdge),
    .winCnt    (winCnt),
    .tick      (tick),
    .pwmGate   (pwmGate),
    .ctl       (ctl),
    .coilL1    (coilL1),
    .coilL2    (coilL2),
    .lockN     (lockN),
    .commStrobe(commStrobe)
  );

  p_one_pair_r1: assert property (@(posedge clk) disable iff (!rstN)
    !(coilL1 && coilL2));

endmodule

// File: tb/fan_commutator_tb.sv
module fan_commutator_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int TICK_CLKS  = 20;
  localparam int FILT       = 4;
  localparam int S1         = 2;
  localparam int S2         = 3;
  localparam int STO        = 4;
  localparam int LK         = 4;
  localparam int HO         = 100;

  logic clk = 1'b0, rstN = 1'b0, hallIn = 1'b0, pwmGate = 1'b1, tick = 1'b0;
  logic coilL1, coilL2, lockN, commStrobe;

  int checks = 0, errors = 0, strobeSeen = 0;
  bit done = 1'b0;

  fan_commutator #(
    .FILT_LEN(FILT), .START_SAMPLE1_TICKS(S1), .START_SAMPLE2_TICKS(S2),
    .SEEK_TIMEOUT_TICKS(STO), .LOCK_TICKS(LK), .HOLDOFF_TICKS(HO)
  ) dut_i (
    .clk(clk), .rstN(rstN), .hallIn(hallIn), .pwmGate(pwmGate), .tick(tick),
    .coilL1(coilL1), .coilL2(coilL2), .lockN(lockN), .commStrobe(commStrobe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    forever begin
      repeat (TICK_CLKS - 1) @(negedge clk);
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // Behavioural reference: 0 align, 1 seek, 2 run, 3 locked.
  int mSync[$];
  int mFilt, mFcnt, mEdge, mWin, mSt, mPh, mStb;

  always @(posedge clk or negedge rstN) begin : refModel
    int clr, nSt, nPh, nStb, s2;
    if (!rstN) begin
      mSync = {0, 0};
      mFilt = 0; mFcnt = 0; mEdge = 0; mWin = 0; mSt = 0; mPh = 0; mStb = 0;
    end else begin
      clr = 0; nSt = mSt; nPh = mPh; nStb = 0;
      case (mSt)
        0: if (tick && ((mWin == S1-1 && mFilt == 1) || mWin == S2-1)) begin nSt = 1; nPh = 1; clr = 1; end
        1: if (mFilt == 0) begin nSt = 2; nPh = 0; clr = 1; end
           else if (tick && mWin == STO-1) begin nSt = 3; clr = 1; end
        2: if (mEdge == 1) begin nPh = 1 - mPh; nStb = 1; clr = 1; end
           else if (tick && mWin == LK-1) begin nSt = 3; clr = 1; end
        default: if (tick && mWin == HO-1) begin nSt = 0; nPh = 0; clr = 1; end
      endcase
      if (clr == 1) mWin = 0;
      else if (tick && mWin < 127) mWin = mWin + 1;
      s2 = mSync[0];
      if (s2 != mFilt) begin
        if (mFcnt == FILT-1) begin mFilt = s2; mFcnt = 0; mEdge = 1; end
        else begin mFcnt = mFcnt + 1; mEdge = 0; end
      end else begin
        mFcnt = 0; mEdge = 0;
      end
      void'(mSync.pop_front());
      mSync.push_back(int'(hallIn));
      mSt = nSt; mPh = nPh; mStb = nStb;
    end
  end

  // Cycle comparison, sampled a quarter period after the rising edge.
  always begin
    @(posedge clk);
    #(CLK_PERIOD/4);
    if (rstN && !done) begin
      automatic int eL1 = (mSt != 3 && mPh == 0 && pwmGate) ? 1 : 0;
      automatic int eL2 = (mSt != 3 && mPh == 1 && pwmGate) ? 1 : 0;
      check(int'(coilL1) == eL1, "R1 coilL1", int'(coilL1), eL1);
      check(int'(coilL2) == eL2, "R1 coilL2", int'(coilL2), eL2);
      check(int'(lockN) == (mSt != 3 ? 1 : 0), "R6 lockN", int'(lockN), (mSt != 3 ? 1 : 0));
      check(int'(commStrobe) == mStb, "R8 commStrobe", int'(commStrobe), mStb);
      if (commStrobe) strobeSeen++;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int base, t0, t1;
    cyc(3);
    rstN = 1'b1;
    cyc(1);
    // R10 reset state
    check(coilL1 == 1'b1 && coilL2 == 1'b0, "R10 coils after reset", int'({coilL1, coilL2}), 2);
    check(lockN == 1'b1 && commStrobe == 1'b0, "R10 flags after reset", int'({lockN, commStrobe}), 2);

    // R3 forward start: hall high before the first sample
    cyc(10); hallIn = 1'b1;
    cyc(60);
    check(coilL2 == 1'b1 && coilL1 == 1'b0, "R3 seek selects L2", int'({coilL1, coilL2}), 1);
    hallIn = 1'b0;
    cyc(12);
    check(coilL1 == 1'b1 && lockN == 1'b1, "R3 run starts on L1", int'({coilL1, lockN}), 3);

    // R2 / R8 rotation: eight edges, each swapping the pair
    base = strobeSeen;
    for (int i = 1; i <= 8; i++) begin
      hallIn = ~hallIn;
      cyc(12);
      check(coilL2 == (i % 2 == 1), "R2 pair after edge", int'(coilL2), (i % 2 == 1) ? 1 : 0);
    end
    check(strobeSeen - base == 8, "R8 strobe count", strobeSeen - base, 8);
    check(lockN == 1'b1, "R5 no lock while rotating", int'(lockN), 1);

    // R1 gate off
    pwmGate = 1'b0; cyc(2);
    check(!coilL1 && !coilL2, "R1 gate low drives nothing", int'({coilL1, coilL2}), 0);
    pwmGate = 1'b1;

    // R9 short glitch
    base = strobeSeen;
    hallIn = 1'b1; cyc(2); hallIn = 1'b0;
    cyc(12);
    check(strobeSeen == base, "R9 glitch ignored strobe", strobeSeen - base, 0);
    check(coilL1 == 1'b1, "R9 glitch ignored pair", int'(coilL1), 1);

    // R5 / R6 stall, then R7 hold-off
    t0 = 0;
    while (lockN && t0 < 200) begin cyc(1); t0++; end
    check(t0 >= (LK-1)*TICK_CLKS - 20 && t0 <= LK*TICK_CLKS, "R5 stall to lock cycles", t0, LK*TICK_CLKS);
    check(!coilL1 && !coilL2 && !lockN, "R6 locked outputs", int'({coilL1, coilL2, lockN}), 0);
    t1 = 0;
    while (!lockN && t1 < 3000) begin cyc(1); t1++; end
    check(t1 >= (HO-1)*TICK_CLKS && t1 <= HO*TICK_CLKS, "R7 hold-off cycles", t1, HO*TICK_CLKS);
    check(coilL1 == 1'b1, "R7 restart on L1", int'(coilL1), 1);

    // R3 reverse path: hall stays low, run begins after the second sample
    cyc(S2*TICK_CLKS + 5);
    check(coilL1 == 1'b1 && lockN == 1'b1, "R3 reverse path reaches run on L1", int'({coilL1, lockN}), 3);
    while (lockN) cyc(1);
    while (!lockN) cyc(1);

    // R4 seek timeout with hall held high
    hallIn = 1'b1;
    cyc(S1*TICK_CLKS + 10);
    check(coilL2 == 1'b1, "R4 seek on L2", int'(coilL2), 1);
    cyc(STO*TICK_CLKS + 5);
    check(lockN == 1'b0, "R4 seek timeout locks", int'(lockN), 0);
    cyc(5);
    finish_run();
  end

endmodule